// File: doc/BRIEF.md
# Boundary-Scan Test Port Controller

This block is the test access port of a boundary-scan chain. It is clocked by the test clock and steps through the sixteen states of the standard test port state machine under control of the mode-select input. It holds a 10-bit instruction path and a one-bit pass-through data register. It also drives the serial output together with an enable that qualifies it. The boundary cells themselves live outside the block. Their serial return is brought in on one input, and the block reports which of the three data modes the loaded instruction selects.

A test host scans an instruction into the block through the instruction-scan branch of the state machine. The value becomes active on the falling clock edge in the update state. A data scan then routes the serial input either through the one-bit pass-through register or out to the external boundary chain. The three opcodes are parameters.

Top module: `scan_port_ctrl`

## Requirements
- R1: The state machine follows the standard sixteen-state graph, reported on `tap_state` with codes RESET=0, IDLE=1, SEL_DR=2, CAP_DR=3, SH_DR=4, EX1_DR=5, PAU_DR=6, EX2_DR=7, UPD_DR=8, SEL_IR=9, CAP_IR=10, SH_IR=11, EX1_IR=12, PAU_IR=13, EX2_IR=14, UPD_IR=15. Five consecutive rising edges with `tms` high reach RESET from any state, and a rising edge with `tap_rst_n` low forces RESET.
- R2: `tdo_oe` is high only while the state is SH_IR or SH_DR. It rises on the first falling edge after a shift state is entered and falls on the first falling edge after one is left.
- R3: `tdi` is sampled on the rising edge of `tck`. `tdo` changes only on the falling edge.
- R4: In CAP_IR the instruction shift stage loads a fixed pattern. It shifts out least significant bit first, so the first ten bits on `tdo` in SH_IR are 1,0,1,0,1,0,1,0,1,0.
- R5: While SH_IR is held longer than ten cycles, `tdo` continues with the bits previously shifted in from `tdi`. After leaving SH_IR, the instruction is the last ten bits shifted, with the latest bit in bit 9. It is copied to `instr` on the falling edge in UPD_IR and does not change in any other state except RESET.
- R6: In RESET the active instruction is forced to the bypass opcode (default 10'h3FF).
- R7: Exactly one of `sel_bypass`, `sel_sample` and `sel_extest` is high. The sample opcode (default 10'h005) selects sample and the external-test opcode (default 10'h00F) selects external test. Every other code selects bypass.
- R8: With bypass selected, CAP_DR clears the pass-through register. The first `tdo` bit in SH_DR is 0, and each later bit equals the `tdi` value sampled on the preceding rising edge.
- R9: With sample or external test selected, `tdo` in SH_DR presents `chain_so` as sampled on each falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tap_rst_n | input | 1 | Active-low reset, sampled on the rising edge |
| tms | input | 1 | Mode select steering the state machine |
| tdi | input | 1 | Serial test data in |
| chain_so | input | 1 | Serial return from the external boundary chain |
| tdo | output | 1 | Serial test data out, valid while `tdo_oe` is high |
| tdo_oe | output | 1 | Output enable for `tdo` |
| instr | output | 10 | Active instruction |
| sel_bypass | output | 1 | Bypass mode selected |
| sel_sample | output | 1 | Sample/preload mode selected |
| sel_extest | output | 1 | External-test mode selected |
| tap_state | output | 4 | Current state code (see R1) |

## Verification
The assertions assume that `tms` and `tdi` change only away from the rising edge of `tck` and that reset is released on a clock edge. They also assume `chain_so` settles before the falling edge at which it is sampled. The bench changes every input a few nanoseconds after a falling edge and samples outputs shortly after the next falling edge. Inputs are therefore stable around both edges the design uses. Scans are driven as complete, legal walks through the state graph. Each walk starts from IDLE or from a five-cycle reset sequence.

// File: rtl/scan_pkg.sv
// Shared types and helpers for the boundary-scan port controller.
// Assumes a 4-bit state code; the code values are visible on the top port.
package scan_pkg;

    typedef enum logic [3:0] {
        ST_RESET  = 4'd0,
        ST_IDLE   = 4'd1,
        ST_SEL_DR = 4'd2,
        ST_CAP_DR = 4'd3,
        ST_SH_DR  = 4'd4,
        ST_EX1_DR = 4'd5,
        ST_PAU_DR = 4'd6,
        ST_EX2_DR = 4'd7,
        ST_UPD_DR = 4'd8,
        ST_SEL_IR = 4'd9,
        ST_CAP_IR = 4'd10,
        ST_SH_IR  = 4'd11,
        ST_EX1_IR = 4'd12,
        ST_PAU_IR = 4'd13,
        ST_EX2_IR = 4'd14,
        ST_UPD_IR = 4'd15
    } tap_state_e;

    // Capture pattern: even bit positions are 1, so LSB-first output reads 1,0,1,0...
    function automatic logic [31:0] capture_pattern(input int width);
        logic [31:0] v;
        v = '0;
        for (int i = 0; i < width; i++) begin
            v[i] = (i % 2 == 0);
        end
        return v;
    endfunction

endpackage

// File: rtl/scan_tap_fsm.sv
// Sixteen-state test port state machine.
// Advances on rising tck under tms; synchronous active-low reset forces RESET.
// Assumes tms is stable around the rising edge.
module scan_tap_fsm
    import scan_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  logic       tms,
    output tap_state_e state_q
);

    tap_state_e state_d;

    // Next-state selection from the current state and tms.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RESET:  state_d = tms ? ST_RESET  : ST_IDLE;
            ST_IDLE:   state_d = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: state_d = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: state_d = tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  state_d = tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: state_d = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: state_d = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: state_d = tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: state_d = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: state_d = tms ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: state_d = tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  state_d = tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: state_d = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: state_d = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: state_d = tms ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: state_d = tms ? ST_SEL_DR : ST_IDLE;
            default:   state_d = ST_RESET;
        endcase
    end

    // State register on rising tck.
    always_ff @(posedge tck) begin
        if (!rst_n) state_q <= ST_RESET;
        else        state_q <= state_d;
    end

endmodule

// File: rtl/scan_ir_unit.sv
// Instruction path: serial shift stage, active instruction latch and mode decode.
// Shift stage moves on rising tck; the latch loads on falling tck in UPD_IR.
// Assumes the opcode parameters are distinct.
module scan_ir_unit
    import scan_pkg::*;
#(
    parameter int             IR_W      = 10,
    parameter logic [IR_W-1:0] OP_BYPASS = '1,
    parameter logic [IR_W-1:0] OP_SAMPLE = IR_W'(5),
    parameter logic [IR_W-1:0] OP_EXTEST = IR_W'(15)
) (
    input  logic            tck,
    input  logic            rst_n,
    input  logic            tdi,
    input  tap_state_e      state,
    output logic [IR_W-1:0] shift_q,
    output logic [IR_W-1:0] instr_q,
    output logic            sel_bypass,
    output logic            sel_sample,
    output logic            sel_extest
);

    localparam logic [IR_W-1:0] CAPTURE = capture_pattern(IR_W)[IR_W-1:0];

    // Shift stage: load the capture pattern, then shift tdi in at the MSB.
    always_ff @(posedge tck) begin
        if (!rst_n)                 shift_q <= CAPTURE;
        else if (state == ST_CAP_IR) shift_q <= CAPTURE;
        else if (state == ST_SH_IR)  shift_q <= {tdi, shift_q[IR_W-1:1]};
    end

    // Active instruction: forced to bypass in RESET, updated on falling tck in UPD_IR.
    always_ff @(negedge tck) begin
        if (!rst_n || state == ST_RESET) instr_q <= OP_BYPASS;
        else if (state == ST_UPD_IR)     instr_q <= shift_q;
    end

    // Mode decode: any code that is not sample or external test falls back to bypass.
    always_comb begin
        sel_sample = (instr_q == OP_SAMPLE);
        sel_extest = (instr_q == OP_EXTEST);
        sel_bypass = !(sel_sample || sel_extest);
    end

endmodule

// File: rtl/scan_bypass_reg.sv
// One-bit pass-through data register.
// Cleared in CAP_DR, loads tdi in SH_DR, both on rising tck.
module scan_bypass_reg
    import scan_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  logic       tdi,
    input  tap_state_e state,
    output logic       byp_q
);

    // Capture zero, then shift tdi through the single stage.
    always_ff @(posedge tck) begin
        if (!rst_n)                  byp_q <= 1'b0;
        else if (state == ST_CAP_DR) byp_q <= 1'b0;
        else if (state == ST_SH_DR)  byp_q <= tdi;
    end

endmodule

// File: rtl/scan_tdo_stage.sv
// Serial output stage, retimed to falling tck.
// The enable is high only in the shift states; data selects the instruction
// stage LSB in SH_IR, else the pass-through bit or the external chain return.
module scan_tdo_stage
    import scan_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  tap_state_e state,
    input  logic       ir_lsb,
    input  logic       byp_bit,
    input  logic       chain_so,
    input  logic       sel_bypass,
    output logic       tdo_q,
    output logic       oe_q
);

    logic tdo_d;

    // Source selection for the next output bit.
    always_comb begin
        if (state == ST_SH_IR) tdo_d = ir_lsb;
        else if (sel_bypass)   tdo_d = byp_bit;
        else                   tdo_d = chain_so;
    end

    // Falling-edge retiming of data and enable.
    always_ff @(negedge tck) begin
        if (!rst_n) begin
            tdo_q <= 1'b0;
            oe_q  <= 1'b0;
        end else begin
            tdo_q <= tdo_d;
            oe_q  <= (state == ST_SH_IR) || (state == ST_SH_DR);
        end
    end

endmodule

// File: rtl/scan_port_ctrl.sv
// Top of the boundary-scan test port controller.
// Connects state machine, instruction path, pass-through register and output stage.
// Assumes an external boundary chain returns its serial data on chain_so.
module scan_port_ctrl
    import scan_pkg::*;
#(
    parameter int              IR_W      = 10,
    parameter logic [IR_W-1:0] OP_BYPASS = '1,
    parameter logic [IR_W-1:0] OP_SAMPLE = IR_W'(5),
    parameter logic [IR_W-1:0] OP_EXTEST = IR_W'(15)
) (
    input  logic            tck,
    input  logic            tap_rst_n,
    input  logic            tms,
    input  logic            tdi,
    input  logic            chain_so,
    output logic            tdo,
    output logic            tdo_oe,
    output logic [IR_W-1:0] instr,
    output logic            sel_bypass,
    output logic            sel_sample,
    output logic            sel_extest,
    output logic [3:0]      tap_state
);

    tap_state_e      state;
    logic [IR_W-1:0] ir_shift;
    logic            byp_bit;

    scan_tap_fsm u_fsm (
        .tck     (tck),
        .rst_n   (tap_rst_n),
        .tms     (tms),
        .state_q (state)
    );

    scan_ir_unit #(
        .IR_W      (IR_W),
        .OP_BYPASS (OP_BYPASS),
        .OP_SAMPLE (OP_SAMPLE),
        .OP_EXTEST (OP_EXTEST)
    ) u_ir (
        .tck        (tck),
        .rst_n      (tap_rst_n),
        .tdi        (tdi),
        .state      (state),
        .shift_q    (ir_shift),
        .instr_q    (instr),
        .sel_bypass (sel_bypass),
        .sel_sample (sel_sample),
        .sel_extest (sel_extest)
    );

    scan_bypass_reg u_byp (
        .tck   (tck),
        .rst_n (tap_rst_n),
        .tdi   (tdi),
        .state (state),
        .byp_q (byp_bit)
    );

    scan_tdo_stage u_out (
        .tck        (tck),
        .rst_n      (tap_rst_n),
        .state      (state),
        .ir_lsb     (ir_shift[0]),
        .byp_bit    (byp_bit),
        .chain_so   (chain_so),
        .sel_bypass (sel_bypass),
        .tdo_q      (tdo),
        .oe_q       (tdo_oe)
    );

    assign tap_state = state;

endmodule

// File: rtl/scan_port_chk.sv
// Property checker for scan_port_ctrl, attached by bind.
// Assumes inputs are stable around the rising edge of tck.
module scan_port_chk
    import scan_pkg::*;
#(
    parameter int IR_W = 10
) (
    input logic            tck,
    input logic            tap_rst_n,
    input logic            tms,
    input logic            tdi,
    input logic            tdo,
    input logic            tdo_oe,
    input logic [3:0]      tap_state,
    input logic [IR_W-1:0] ir_shift,
    input logic [IR_W-1:0] instr,
    input logic            sel_bypass,
    input logic            sel_sample,
    input logic            sel_extest
);

    localparam logic [IR_W-1:0] CAPTURE = capture_pattern(IR_W)[IR_W-1:0];

    p_tms_reset_r1: assert property (@(posedge tck) disable iff (!tap_rst_n)
        (tms && $past(tms) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4))
        |=> (tap_state == ST_RESET));

    p_oe_window_r2: assert property (@(posedge tck) disable iff (!tap_rst_n)
        tdo_oe == ((tap_state == ST_SH_IR) || (tap_state == ST_SH_DR)));

    p_ir_capture_r4: assert property (@(posedge tck) disable iff (!tap_rst_n)
        (tap_state == ST_CAP_IR) |=> (ir_shift == CAPTURE));

    p_instr_hold_r5: assert property (@(posedge tck) disable iff (!tap_rst_n)
        ((tap_state != ST_UPD_IR) && (tap_state != ST_RESET)) |-> $stable(instr));

    p_reset_bypass_r6: assert property (@(posedge tck) disable iff (!tap_rst_n)
        (tap_state == ST_RESET) |=> sel_bypass);

    p_one_mode_r7: assert property (@(posedge tck) disable iff (!tap_rst_n)
        $countones({sel_bypass, sel_sample, sel_extest}) == 1);

    p_bypass_delay_r8: assert property (@(posedge tck) disable iff (!tap_rst_n)
        ((tap_state == ST_SH_DR) && sel_bypass) |=> (tdo == $past(tdi)));

endmodule

bind scan_port_ctrl scan_port_chk #(.IR_W(IR_W)) u_chk (
    .tck        (tck),
    .tap_rst_n  (tap_rst_n),
    .tms        (tms),
    .tdi        (tdi),
    .tdo        (tdo),
    .tdo_oe     (tdo_oe),
    .tap_state  (tap_state),
    .ir_shift   (ir_shift),
    .instr      (instr),
    .sel_bypass (sel_bypass),
    .sel_sample (sel_sample),
    .sel_extest (sel_extest)
);

// File: tb/tb_scan_port_ctrl.sv
// Scoreboard bench: scan tasks queue the expected serial bits, and a monitor
// pops them on every enabled falling edge.
module tb_scan_port_ctrl;

    localparam int IR_W = 10;
    localparam logic [IR_W-1:0] OPB = 10'h3FF;
    localparam logic [IR_W-1:0] OPS = 10'h005;
    localparam logic [IR_W-1:0] OPE = 10'h00F;

    logic tck = 1'b0;
    logic tap_rst_n = 1'b0;
    logic tms = 1'b1;
    logic tdi = 1'b0;
    logic chain_so = 1'b0;
    logic tdo, tdo_oe, sel_bypass, sel_sample, sel_extest;
    logic [IR_W-1:0] instr;
    logic [3:0] tap_state;

    int n_run = 0;
    int n_fail = 0;
    bit exp_q[$];
    bit finished = 0;

    always #10 tck = ~tck;

    scan_port_ctrl dut (
        .tck (tck), .tap_rst_n (tap_rst_n), .tms (tms), .tdi (tdi),
        .chain_so (chain_so), .tdo (tdo), .tdo_oe (tdo_oe), .instr (instr),
        .sel_bypass (sel_bypass), .sel_sample (sel_sample),
        .sel_extest (sel_extest), .tap_state (tap_state)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: each enabled falling edge consumes one expected bit (R2/R4/R5/R8/R9).
    initial begin
        forever begin
            @(negedge tck);
            #2;
            if (tap_rst_n && tdo_oe) begin
                n_run++;
                if (exp_q.size() == 0) begin
                    n_fail++;
                    $display("FAIL R2 actual=oe_high expected=oe_low (no item queued)");
                end else begin
                    bit e;
                    e = exp_q.pop_front();
                    if (tdo !== e) begin
                        n_fail++;
                        $display("FAIL R4/R5/R8/R9 serial actual=%0b expected=%0b", tdo, e);
                    end
                end
            end
        end
    end

    // One test clock: inputs applied after the falling edge, outputs read after the next.
    task automatic step(input logic t, input logic d);
        tms = t;
        tdi = d;
        @(posedge tck);
        @(negedge tck);
        #2;
    endtask

    task automatic to_idle();
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
        step(1'b0, 1'b0);
    endtask

    // Instruction scan of n bits from IDLE back to IDLE.
    task automatic scan_ir(input logic [31:0] data, input int n);
        for (int i = 0; i < n; i++) begin
            if (i < IR_W) exp_q.push_back(i % 2 == 0);
            else          exp_q.push_back(data[i - IR_W]);
        end
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        chk("R1 CAP_IR code", tap_state, 10);
        step(1'b0, 1'b0);
        chk("R1 SH_IR code", tap_state, 11);
        for (int i = 0; i < n; i++) step(i == n - 1, data[i]);
        chk("R2 oe low in EX1_IR", tdo_oe, 0);
        chk("R1 EX1_IR code", tap_state, 12);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        chk("R1 IDLE code", tap_state, 1);
        chk("R1 queue drained after IR scan", exp_q.size(), 0);
    endtask

    // Data scan of n bits; byp picks the pass-through expectation, else chain_so.
    task automatic scan_dr(input logic [31:0] data, input int n, input bit byp);
        exp_q.push_back(byp ? 1'b0 : chain_so);
        for (int i = 0; i < n - 1; i++) exp_q.push_back(byp ? data[i] : chain_so);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        chk("R1 CAP_DR code", tap_state, 3);
        step(1'b0, 1'b0);
        chk("R1 SH_DR code", tap_state, 4);
        for (int i = 0; i < n; i++) step(i == n - 1, data[i]);
        chk("R2 oe low in EX1_DR", tdo_oe, 0);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        chk("R1 queue drained after DR scan", exp_q.size(), 0);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 20);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge tck);
        #2;
        // R1/R2/R6: reset state
        chk("R1 reset state", tap_state, 0);
        chk("R2 oe low in reset", tdo_oe, 0);
        chk("R6 bypass opcode after reset", instr, OPB);
        chk("R7 bypass selected after reset", sel_bypass, 1);
        tap_rst_n = 1'b1;
        to_idle();
        chk("R1 idle after tms low", tap_state, 1);

        // R4: plain 10-bit load of sample opcode
        scan_ir(32'(OPS), 10);
        chk("R5 sample opcode latched", instr, OPS);
        chk("R7 sample select", sel_sample, 1);
        chk("R7 bypass off", sel_bypass, 0);

        // R9: sample mode data path from chain return
        chain_so = 1'b1;
        scan_dr(32'h0, 4, 1'b0);

        // R5: 14-bit hold, last ten bits form the external-test opcode
        scan_ir({18'h0, OPE, 4'b0110}, 14);
        chk("R5 extest opcode from last ten bits", instr, OPE);
        chk("R7 extest select", sel_extest, 1);
        chain_so = 1'b0;
        scan_dr(32'hF, 4, 1'b0);

        // R7: undefined code falls back to bypass; R8 bypass path
        scan_ir(32'h2AA, 10);
        chk("R7 undefined opcode instr", instr, 10'h2AA);
        chk("R7 undefined opcode selects bypass", sel_bypass, 1);
        scan_dr(32'b1011_0010, 8, 1'b1);

        // R1: five tms-high cycles from SH_DR reach reset; R6 forces bypass opcode
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        exp_q.push_back(1'b0);
        step(1'b0, 1'b0);
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
        chk("R1 five tms high reach reset", tap_state, 0);
        chk("R6 opcode forced in reset", instr, OPB);
        step(1'b0, 1'b0);

        // R3: tdo holds across the rising edge and changes at the falling edge
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        exp_q.push_back(1'b0);
        step(1'b0, 1'b0);
        exp_q.push_back(1'b1);
        tms = 1'b0;
        tdi = 1'b1;
        @(posedge tck);
        #2;
        chk("R3 tdo unchanged after rising edge", tdo, 0);
        @(negedge tck);
        #2;
        chk("R3 tdo updated at falling edge", tdo, 1);
        step(1'b1, 1'b0);
        chk("R2 oe low after leaving SH_DR", tdo_oe, 0);
        chk("R3 queue drained", exp_q.size(), 0);
        to_idle();

        summary();
    end

endmodule